// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block gathers six interrupt source lines into one status register and drives a single interrupt request toward a processor. Each source line is treated as asynchronous. It passes through a synchroniser and then a rising-edge detector. A detected edge sets the source's status bit only when that source is enabled in the enable register. Once set, the bit stays set for as long as the source remains enabled.

No register exists for clearing status. Software clears a status bit by writing its enable bit to 0, and re-arms the source by writing the enable bit back to 1. The request fires only when the status register as a whole changes from all zero to non-zero. A build parameter selects the request form:

- **Pulse form:** a single-cycle strobe.
- **Level form:** a level that stays high while any status bit is set.

Software reaches the registers through a small register bus. A write takes effect on the clock edge at which it is presented. Read data is registered, so it appears one cycle after the address.

Top module: `irq_latch_ctrl`

## Requirements
- R1: Reset (synchronous, active high) clears the enable register, the status register, the read data output and the request output to zero.
- R2: Address 0 holds the 6-bit enable register. A write there replaces it, and a read returns its value. Read data appears on the clock edge after the address is presented.
- R3: Address 1 returns the 6-bit status register. A rising edge on an enabled source sets that source's bit; bit i belongs to source input bit i. The edge takes effect two clock edges after the input changes plus one more for the latch. The bit then stays set while the source stays enabled, whatever the source does afterwards.
- R4: While a source's enable bit is 0, its status bit reads 0 and edges on that source are ignored.
- R5: Writing an enable bit to 0 clears that status bit on the same clock edge. Nothing else clears status, and a write to address 1 has no effect.
- R6: An edge whose latch cycle is the same cycle as the write that enables its source is not latched. An edge that arrives one cycle after the enable write is latched.
- R7: In pulse form, the request is high for exactly one cycle. That cycle follows the first cycle in which the status register is non-zero after being all zero.
- R8: While the status register stays non-zero, new edges on other enabled sources produce no further request pulse.
- R9: In level form, the request equals "status non-zero" delayed by one cycle.
- R10: Reading any address changes neither status, enable nor the request.
- R11: Reads of addresses 2 and 3 return zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Asynchronous interrupt source lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 enable, 1 status) |
| reg_wdata_i | input | NUM_SRC | Register write data |
| reg_rdata_o | output | NUM_SRC | Registered read data |
| irq_o | output | 1 | Interrupt request (pulse or level form) |

## Verification
A status bit stuck at 1 shows at the ports in two ways. The status read returns the wrong value on the cycle after the address is presented. The request also never fires again, because the register never returns to zero. A bit that fails to clear with its enable bit shows at the next status read.

A wrong status bit can also show as a missing or doubled request pulse. This appears within three cycles of the source edge, so each vector counts pulses and checks the mirrored level-form request alongside the read-back values. The directed test of the enable race checks the single cycle in which the latch mask decides.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  localparam int unsigned REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] ADDR_ENABLE = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 2'd1;

  typedef enum logic {
    REQ_PULSE = 1'b0,
    REQ_LEVEL = 1'b1
  } req_mode_e;

endpackage

// File: rtl/irq_src_edge.sv
// Per-source synchroniser chain followed by a rising-edge detector.
module irq_src_edge #(
  parameter int unsigned NUM_SRC     = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_async_i,
  output logic [NUM_SRC-1:0] rise_o
);

  localparam int unsigned TOP = SYNC_STAGES - 1;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   seen_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
        seen_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[SYNC_STAGES-2:0], src_async_i[i]};
        seen_q  <= chain_q[TOP];
      end
    end

    assign rise_o[i] = chain_q[TOP] & ~seen_q;
  end

endmodule

// File: rtl/irq_status_bank.sv
// Enable and status registers. Status is masked by the enable value of the
// current cycle for setting and by the next enable value for clearing.
module irq_status_bank #(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  input  logic [NUM_SRC-1:0] rise_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] status_o
);

  logic [NUM_SRC-1:0] en_q, en_next;
  logic [NUM_SRC-1:0] status_q, status_next;

  always_comb begin
    en_next     = en_wr_i ? en_wdata_i : en_q;
    status_next = en_next & (status_q | (rise_i & en_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      status_q <= '0;
    end else begin
      en_q     <= en_next;
      status_q <= status_next;
    end
  end

  assign en_o     = en_q;
  assign status_o = status_q;

endmodule

// File: rtl/irq_req_gen.sv
// Request generator: strobe on the zero-to-non-zero transition or level.
module irq_req_gen
  import irq_latch_pkg::*;
#(
  parameter int unsigned NUM_SRC = 6,
  parameter req_mode_e   MODE    = REQ_PULSE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] status_i,
  output logic               irq_o
);

  logic any_now;
  logic irq_q;

  assign any_now = |status_i;

  if (MODE == REQ_LEVEL) begin : g_level
    always_ff @(posedge clk) begin
      if (rst) irq_q <= 1'b0;
      else     irq_q <= any_now;
    end
  end else begin : g_pulse
    logic any_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        any_q <= 1'b0;
        irq_q <= 1'b0;
      end else begin
        any_q <= any_now;
        irq_q <= any_now & ~any_q;
      end
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          LEVEL_MODE  = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC-1:0]    src_i,
  input  logic                  reg_wr_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [NUM_SRC-1:0]    reg_wdata_i,
  output logic [NUM_SRC-1:0]    reg_rdata_o,
  output logic                  irq_o
);

  localparam req_mode_e MODE = LEVEL_MODE ? REQ_LEVEL : REQ_PULSE;

  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] status_q;
  logic               en_wr;
  logic [NUM_SRC-1:0] rdata_q;

  assign en_wr = reg_wr_i && (reg_addr_i == ADDR_ENABLE);

  irq_src_edge #(
    .NUM_SRC    (NUM_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk        (clk),
    .rst        (rst),
    .src_async_i(src_i),
    .rise_o     (rise)
  );

  irq_status_bank #(
    .NUM_SRC(NUM_SRC)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .en_wr_i   (en_wr),
    .en_wdata_i(reg_wdata_i),
    .rise_i    (rise),
    .en_o      (en_q),
    .status_o  (status_q)
  );

  irq_req_gen #(
    .NUM_SRC(NUM_SRC),
    .MODE   (MODE)
  ) u_req (
    .clk     (clk),
    .rst     (rst),
    .status_i(status_q),
    .irq_o   (irq_o)
  );

  // Registered read mux; reads carry no side effects.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (reg_addr_i)
        ADDR_ENABLE: rdata_q <= en_q;
        ADDR_STATUS: rdata_q <= status_q;
        default:     rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata_o = rdata_q;

endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk #(
  parameter int unsigned NUM_SRC    = 6,
  parameter bit          LEVEL_MODE = 1'b0
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] status_q,
  input logic               irq_o
);

  // R4
  status_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q & ~en_q) == '0);

  // R3
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(status_q) & en_q & ~status_q) == '0));

  // R6
  no_unmasked_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en_q)) == '0));

  if (LEVEL_MODE) begin : g_level
    // R9
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (irq_o == ($past(status_q) != '0)));
  end else begin : g_pulse
    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
      irq_o |=> !irq_o);
    // R8
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
      irq_o |-> (($past(status_q) != '0) && ($past(status_q, 2) == '0)));
  end

endmodule

bind irq_latch_ctrl irq_latch_chk #(
  .NUM_SRC   (NUM_SRC),
  .LEVEL_MODE(LEVEL_MODE)
) u_irq_latch_chk (
  .clk     (clk),
  .rst     (rst),
  .en_q    (en_q),
  .status_q(status_q),
  .irq_o   (irq_o)
);

// File: tb/test_irq_latch_ctrl.sv
`timescale 1ns/1ps
module test_irq_latch_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] src = '0;
  logic       wr = 1'b0;
  logic [1:0] addr = '0;
  logic [5:0] wdata = '0;
  logic [5:0] rdata, rdata_lvl;
  logic       irq, irq_lvl;

  int n_tests = 0;
  int n_fail  = 0;
  int pulse_total = 0;

  always #4 clk = ~clk;

  irq_latch_ctrl i_irq_latch_ctrl (
    .clk(clk), .rst(rst), .src_i(src), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  irq_latch_ctrl #(.LEVEL_MODE(1'b1)) i_irq_latch_ctrl_lvl (
    .clk(clk), .rst(rst), .src_i(src), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_lvl), .irq_o(irq_lvl)
  );

  always @(negedge clk) if (irq) pulse_total++;

  // {enable[23:18], source[17:12], expected status[11:6], expected pulses[5:0]}
  localparam logic [23:0] VEC [10] = '{
    {6'h3F, 6'h01, 6'h01, 6'd1},
    {6'h3F, 6'h06, 6'h07, 6'd0},
    {6'h38, 6'h00, 6'h00, 6'd0},
    {6'h38, 6'h09, 6'h08, 6'd1},
    {6'h30, 6'h00, 6'h00, 6'd0},
    {6'h00, 6'h3F, 6'h00, 6'd0},
    {6'h3F, 6'h3F, 6'h3F, 6'd1},
    {6'h20, 6'h20, 6'h20, 6'd0},
    {6'h00, 6'h00, 6'h00, 6'd0},
    {6'h10, 6'h10, 6'h10, 6'd1}
  };

  task automatic summary_and_end();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [5:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [5:0] d);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary_and_end();
  end

  initial begin
    logic [5:0] d;
    int p0;

    // Reset state (R1)
    wait_cyc(3);
    @(negedge clk);
    check("R1", "rdata in reset", int'(rdata), 0);
    check("R1", "irq in reset", int'(irq), 0);
    check("R1", "level irq in reset", int'(irq_lvl), 0);
    rst = 1'b0;
    read_reg(2'd0, d); check("R1", "enable after reset", int'(d), 0);
    read_reg(2'd1, d); check("R1", "status after reset", int'(d), 0);

    // Vector table (R2 R3 R4 R5 R7 R8 R9)
    for (int v = 0; v < 10; v++) begin
      p0 = pulse_total;
      write_reg(2'd0, VEC[v][23:18]);
      @(negedge clk); src = '0;
      wait_cyc(4);
      @(negedge clk); src = VEC[v][17:12];
      wait_cyc(6);
      read_reg(2'd0, d);
      check("R2", $sformatf("vec %0d enable readback", v), int'(d), int'(VEC[v][23:18]));
      read_reg(2'd1, d);
      check("R3 R4 R5", $sformatf("vec %0d status", v), int'(d), int'(VEC[v][11:6]));
      check("R7 R8", $sformatf("vec %0d pulse count", v), pulse_total - p0, int'(VEC[v][5:0]));
      check("R9", $sformatf("vec %0d level irq", v), int'(irq_lvl), int'(VEC[v][11:6] != 6'h00));
    end

    // Status write ignored, reads side-effect free, unused addresses (R5 R10 R11)
    p0 = pulse_total;
    write_reg(2'd1, 6'h00);
    write_reg(2'd3, 6'h3F);
    read_reg(2'd1, d); check("R5", "status after write to status address", int'(d), 'h10);
    read_reg(2'd1, d); read_reg(2'd1, d);
    check("R10", "status after repeated reads", int'(d), 'h10);
    check("R10", "no pulse from reads", pulse_total - p0, 0);
    check("R10", "level irq unchanged by reads", int'(irq_lvl), 1);
    read_reg(2'd2, d); check("R11", "address 2 reads zero", int'(d), 0);
    read_reg(2'd3, d); check("R11", "address 3 reads zero", int'(d), 0);
    read_reg(2'd0, d); check("R11", "enable untouched by address 3 write", int'(d), 'h10);

    // Edge in the same cycle as the enable write is dropped (R6)
    write_reg(2'd0, 6'h00);
    @(negedge clk); src = '0;
    wait_cyc(4);
    @(negedge clk); src = 6'h01;
    @(posedge clk);
    @(posedge clk);
    write_reg(2'd0, 6'h01);
    wait_cyc(4);
    read_reg(2'd1, d); check("R6", "edge coinciding with enable not latched", int'(d), 0);

    // Edge one cycle after the enable write is latched (R6)
    p0 = pulse_total;
    @(negedge clk); src = 6'h03;
    @(posedge clk);
    write_reg(2'd0, 6'h03);
    wait_cyc(4);
    read_reg(2'd1, d); check("R6", "edge after enable latched", int'(d), 'h02);
    check("R7", "pulse on first latch", pulse_total - p0, 1);

    // Reset with status set (R1)
    @(negedge clk); rst = 1'b1;
    wait_cyc(2);
    @(negedge clk);
    check("R1", "rdata after mid reset", int'(rdata), 0);
    check("R1", "level irq after mid reset", int'(irq_lvl), 0);
    rst = 1'b0;
    read_reg(2'd1, d); check("R1", "status after mid reset", int'(d), 0);
    read_reg(2'd0, d); check("R1", "enable after mid reset", int'(d), 0);

    summary_and_end();
  end

endmodule